// File: doc/BRIEF.md
# Self-Starting Five-Code Sequence Counter

This block is a 3-bit synchronous counter. It does not count in binary. Each enabled clock moves it one step around a fixed ring of five codes. The code is read with C as the most significant bit, then B, then A.

The three codes that lie outside the ring are never left undefined. Each has its own next state, so a register that powers up holding one of them is back on the ring after one enabled clock. A valid flag shows, in the same cycle, whether the present code belongs to the ring.

A load port writes any 3-bit code straight into the state register. This lets a test reach the unused codes and watch the counter recover from them.

Top module: `seq_counter`

## Requirements
- R1: While `rst_ni` is low the state is 3'b000, and it takes that value at once, without waiting for a clock edge.
- R2: With `cnt_en_i` high and `load_i` low, each clock moves the state around the ring 000, 010, 011, 101, 110 and then back to 000.
- R3: With `cnt_en_i` and `load_i` both low, the state keeps its value across a clock edge, whether that value is on the ring or not.
- R4: With the counter enabled, the unused code 001 is followed by 010.
- R5: With the counter enabled, the unused code 100 is followed by 000.
- R6: With the counter enabled, the unused code 111 is followed by 000.
- R7: `valid_o` is 1 exactly when the state is 000, 010, 011, 101 or 110, and 0 for 001, 100 and 111.
- R8: With `load_i` high, the next clock writes `load_code_i` into the state, whatever `cnt_en_i` is.
- R9: From any state that is off the ring, one enabled clock without a load lands the counter on the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Step enable |
| load_i | input | 1 | Write `load_code_i` into the state (debug path) |
| load_code_i | input | 3 | Code to be written by a load |
| state_o | output | 3 | Present code, bit 2 = C, bit 0 = A |
| valid_o | output | 1 | High when the present code is on the ring |

## Verification
The bench loads each of the three unused codes and steps once from each.

- If a recovery path had been left as a don't-care, the counter would either lock on that code or land on a wrong one.
- Holding an unused code with the enable low checks that hold works off the ring. A design that quietly repaired the code while idle would fail this check.
- A load with the enable high checks that the load wins. If the enable won instead, the counter would step from the old code and ignore the written one.
- Asserting reset between clock edges shows whether the reset is truly asynchronous.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned CODE_W = 3;
  typedef logic [CODE_W-1:0] code_t;

  localparam code_t S0 = 3'b000;
  localparam code_t S1 = 3'b010;
  localparam code_t S2 = 3'b011;
  localparam code_t S3 = 3'b101;
  localparam code_t S4 = 3'b110;
  localparam code_t U0 = 3'b001;
  localparam code_t U1 = 3'b100;
  localparam code_t U2 = 3'b111;
endpackage

// File: rtl/seq_next.sv
module seq_next
  import seq_pkg::*;
(
  input  code_t cur_i,
  output code_t nxt_o
);
  // Full table: every unused code has a defined exit onto the ring
  always_comb begin
    unique case (cur_i)
      S0:      nxt_o = S1;
      S1:      nxt_o = S2;
      S2:      nxt_o = S3;
      S3:      nxt_o = S4;
      S4:      nxt_o = S0;
      U0:      nxt_o = S1;
      U1:      nxt_o = S0;
      U2:      nxt_o = S0;
      default: nxt_o = S0;
    endcase
  end
endmodule

// File: rtl/seq_valid.sv
module seq_valid
  import seq_pkg::*;
(
  input  code_t cur_i,
  output logic  valid_o
);
  always_comb begin
    unique case (cur_i)
      S0, S1, S2, S3, S4: valid_o = 1'b1;
      default:            valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/seq_reg.sv
module seq_reg
  import seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cnt_en_i,
  input  logic  load_i,
  input  code_t load_code_i,
  input  code_t nxt_i,
  output code_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= S0;
    else if (load_i)   q_o <= load_code_i;
    else if (cnt_en_i) q_o <= nxt_i;
  end

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !cnt_en_i) |=> $stable(q_o));

  p_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (q_o == $past(load_code_i)));

  p_code100_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_en_i && q_o == U1) |=> (q_o == S0));
endmodule

// File: rtl/seq_counter.sv
module seq_counter
  import seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] load_code_i,
  output logic [CODE_W-1:0] state_o,
  output logic              valid_o
);
  code_t cur, nxt;

  seq_next u_next (
    .cur_i (cur),
    .nxt_o (nxt)
  );

  seq_reg u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_en_i    (cnt_en_i),
    .load_i      (load_i),
    .load_code_i (load_code_i),
    .nxt_i       (nxt),
    .q_o         (cur)
  );

  seq_valid u_valid (
    .cur_i   (cur),
    .valid_o (valid_o)
  );

  assign state_o = cur;

  p_recover_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !load_i && !valid_o) |=> valid_o);

  p_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !load_i && valid_o) |=> (valid_o && state_o != $past(state_o)));
endmodule

// File: tb/seq_counter_test.sv
module seq_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       ld = 1'b0;
  logic [2:0] ld_code = 3'b000;
  logic [2:0] state;
  logic       valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seq_counter uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cnt_en_i    (en),
    .load_i      (ld),
    .load_code_i (ld_code),
    .state_o     (state),
    .valid_o     (valid)
  );

  // {load, load_code, enable, expected state, expected valid}
  localparam int NV = 14;
  localparam logic [8:0] VEC [NV] = '{
    {1'b1, 3'b001, 1'b0, 3'b001, 1'b0}, // R8 R7
    {1'b0, 3'b000, 1'b1, 3'b010, 1'b1}, // R4
    {1'b0, 3'b000, 1'b1, 3'b011, 1'b1}, // R2
    {1'b0, 3'b000, 1'b1, 3'b101, 1'b1}, // R2
    {1'b0, 3'b000, 1'b0, 3'b101, 1'b1}, // R3
    {1'b0, 3'b000, 1'b1, 3'b110, 1'b1}, // R2
    {1'b0, 3'b000, 1'b1, 3'b000, 1'b1}, // R2
    {1'b1, 3'b100, 1'b0, 3'b100, 1'b0}, // R8 R7
    {1'b0, 3'b000, 1'b1, 3'b000, 1'b1}, // R5 R9
    {1'b1, 3'b111, 1'b0, 3'b111, 1'b0}, // R8 R7
    {1'b0, 3'b000, 1'b0, 3'b111, 1'b0}, // R3 hold off-ring
    {1'b0, 3'b000, 1'b1, 3'b000, 1'b1}, // R6 R9
    {1'b1, 3'b011, 1'b1, 3'b011, 1'b1}, // R8 load beats enable
    {1'b0, 3'b000, 1'b1, 3'b101, 1'b1}  // R2
  };

  task automatic check(input string req, input logic [2:0] exp_s, input logic exp_v);
    checks++;
    if (state !== exp_s || valid !== exp_v) begin
      errors++;
      $display("FAIL %s: state=%b valid=%b expected state=%b valid=%b",
               req, state, valid, exp_s, exp_v);
    end
  endtask

  task automatic step(input logic l, input logic [2:0] c, input logic e);
    @(negedge clk);
    ld = l; ld_code = c; en = e;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1;
    check("R1", 3'b000, 1'b1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][8], VEC[i][7:5], VEC[i][4]);
      check($sformatf("vec%0d R2/R3/R4/R5/R6/R7/R8/R9", i), VEC[i][3:1], VEC[i][0]);
    end

    // Full ring from reset: R2
    step(1'b1, 3'b000, 1'b0);
    step(1'b0, 3'b000, 1'b1); check("R2", 3'b010, 1'b1);
    step(1'b0, 3'b000, 1'b1); check("R2", 3'b011, 1'b1);
    step(1'b0, 3'b000, 1'b1); check("R2", 3'b101, 1'b1);
    step(1'b0, 3'b000, 1'b1); check("R2", 3'b110, 1'b1);
    step(1'b0, 3'b000, 1'b1); check("R2", 3'b000, 1'b1);

    // Each unused code recovers in one enabled clock: R9
    step(1'b1, 3'b001, 1'b0);
    step(1'b0, 3'b000, 1'b1); check("R9 from 001", 3'b010, 1'b1);
    step(1'b1, 3'b111, 1'b0);
    step(1'b0, 3'b000, 1'b1); check("R9 from 111", 3'b000, 1'b1);

    // Hold on an unused code: R3
    step(1'b1, 3'b100, 1'b0);
    step(1'b0, 3'b000, 1'b0); check("R3 hold 100", 3'b100, 1'b0);

    // Asynchronous reset between edges: R1
    step(1'b1, 3'b110, 1'b0);
    ld = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check("R1 async", 3'b000, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 3'b000, 1'b1); check("R1 restart", 3'b010, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule